// File: doc/BRIEF.md
# Jumping LFSR Test-Pattern Generator

This block is a 16-bit linear feedback shift register used as a pseudo-random pattern source for scan-based self-test. On every enabled clock it advances its state in one of two ways. In single-step mode it moves one position along its maximal-length sequence through the polynomial feedback. In jump mode a second XOR-only network takes the place of that feedback and writes, in one clock, the state that lies a fixed number of single steps ahead. A controller uses jump mode to pass quickly over stretches of the sequence that hold no useful patterns, and single-step mode where the patterns are applied.

A new seed can be loaded at any time for reseeding. A seed of zero would lock the register at zero, so the block replaces it with a nonzero default. The full state leaves the block as a parallel word that feeds the scan chains. The jump network is built at elaboration by raising the one-step transition matrix to the power of the jump distance over GF(2). Changing the width, taps or distance therefore needs no hand-written equations.

Top module: `sslfsr_gen`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises with load low and en low, `state` equals DEFAULT_SEED (16'hACE1).
- R2: When `load` is high at a rising clock edge, `state` takes the guarded seed on that edge, whatever the values of `en` and `jump`.
- R3: A loaded seed of 16'h0000 is replaced by DEFAULT_SEED (16'hACE1). Any nonzero seed is taken unchanged.
- R4: With `load` low and `en` low, `state` keeps its value across the clock edge, whatever `jump` is.
- R5: With `load` low, `en` high and `jump` low (single-step mode), the next state is {state[14:0], fb}, where fb is the XOR of state bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1).
- R6: With `load` low, `en` high and `jump` high (jump mode), the next state equals the state that SKIP=8 consecutive single steps would reach from the present state.
- R7: `jump` is sampled on every enabled clock, so single steps and jumps may be mixed in any order, and each edge follows the mode present at that edge.
- R8: Stepping in single-step mode from a nonzero state returns to that state after exactly 65535 steps, and `state` is never zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance enable |
| load | input | 1 | Load `seed` on this edge; has priority over stepping |
| seed | input | 16 | Reseed value |
| jump | input | 1 | 0 = single step, 1 = jump SKIP steps |
| state | output | 16 | Parallel register state for the scan chains |

## Verification
The assertions assume that `en`, `load`, `jump` and `seed` are known, two-valued levels at every rising edge once reset is released. They also assume that reset is only released after at least one clock edge with rst_n low, so that the register starts from DEFAULT_SEED. The bench changes every input one time unit after a rising edge and holds rst_n low for three edges, so the inputs are stable at each sampling edge and every input stays inside those assumptions.

// File: rtl/sslfsr_pkg.sv
// Shared types for the jumping LFSR pattern generator.
// Assumes nothing beyond a 1-bit mode select.
package sslfsr_pkg;

    // How the register advances on an enabled clock.
    typedef enum logic {
        ADV_SINGLE = 1'b0,
        ADV_JUMP   = 1'b1
    } adv_mode_e;

endpackage

// File: rtl/sslfsr_single_net.sv
// Single-step Fibonacci feedback network.
// Shifts the state left by one and inserts the parity of the tapped bits at bit 0.
// Assumes TAP_MASK describes a primitive polynomial (bit j set = state bit j tapped).
module sslfsr_single_net #(
    parameter int            N        = 16,
    parameter logic [N-1:0]  TAP_MASK = 16'hB400
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);

    logic fb;

    // Feedback bit: parity of the tapped state bits.
    assign fb = ^(cur & TAP_MASK);

    // Shift toward the MSB and insert the feedback bit.
    assign nxt = {cur[N-2:0], fb};

endmodule

// File: rtl/sslfsr_skip_net.sv
// Jump network: computes the state SKIP single steps ahead in one pass.
// The GF(2) matrix is the SKIP-th power of the single-step matrix and is
// worked out at elaboration; each output bit is the parity of a fixed mask.
// Assumes SKIP >= 1 and the same TAP_MASK as the single-step network.
module sslfsr_skip_net #(
    parameter int            N        = 16,
    parameter logic [N-1:0]  TAP_MASK = 16'hB400,
    parameter int            SKIP     = 8
) (
    input  logic [N-1:0] cur,
    output logic [N-1:0] nxt
);

    localparam int MAT_BITS = N * N;

    // Row i is the mask of starting-state bits whose parity gives bit i after SKIP steps.
    function automatic logic [MAT_BITS-1:0] build_jump_matrix();
        logic [N-1:0][N-1:0] rows;
        logic [N-1:0][N-1:0] nrows;
        logic [MAT_BITS-1:0] flat;
        for (int i = 0; i < N; i++) begin
            rows[i]    = '0;
            rows[i][i] = 1'b1;
        end
        for (int s = 0; s < SKIP; s++) begin
            nrows[0] = '0;
            for (int j = 0; j < N; j++) begin
                if (TAP_MASK[j]) nrows[0] = nrows[0] ^ rows[j];
            end
            for (int i = 1; i < N; i++) begin
                nrows[i] = rows[i-1];
            end
            rows = nrows;
        end
        for (int i = 0; i < N; i++) begin
            flat[i*N +: N] = rows[i];
        end
        return flat;
    endfunction

    localparam logic [MAT_BITS-1:0] JMAT = build_jump_matrix();

    // One parity tree for each output bit.
    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_row
            assign nxt[gi] = ^(cur & JMAT[gi*N +: N]);
        end
    endgenerate

endmodule

// File: rtl/sslfsr_seed_guard.sv
// Seed guard: replaces an all-zero seed with a nonzero default, so the
// register can never enter the lock-up state.
// Assumes DEFAULT_SEED is nonzero.
module sslfsr_seed_guard #(
    parameter int            N            = 16,
    parameter logic [N-1:0]  DEFAULT_SEED = 16'hACE1
) (
    input  logic [N-1:0] seed_in,
    output logic [N-1:0] seed_out
);

    // Substitute the default when the incoming seed is zero.
    assign seed_out = (seed_in == '0) ? DEFAULT_SEED : seed_in;

endmodule

// File: rtl/sslfsr_gen.sv
// Top level of the jumping LFSR pattern generator.
// Priority at each edge: reset, then load, then enable (single step or jump), else hold.
// Assumes synchronous active-low reset and inputs stable around the clock edge.
module sslfsr_gen #(
    parameter int            N            = 16,
    parameter logic [N-1:0]  TAP_MASK     = 16'hB400,
    parameter int            SKIP         = 8,
    parameter logic [N-1:0]  DEFAULT_SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [N-1:0] seed,
    input  logic         jump,
    output logic [N-1:0] state
);

    import sslfsr_pkg::*;

    logic [N-1:0] state_q;
    logic [N-1:0] single_nxt;
    logic [N-1:0] jump_nxt;
    logic [N-1:0] seed_safe;
    logic [N-1:0] state_d;
    adv_mode_e    mode;

    sslfsr_single_net #(.N(N), .TAP_MASK(TAP_MASK)) u_single (
        .cur (state_q),
        .nxt (single_nxt)
    );

    sslfsr_skip_net #(.N(N), .TAP_MASK(TAP_MASK), .SKIP(SKIP)) u_skip (
        .cur (state_q),
        .nxt (jump_nxt)
    );

    sslfsr_seed_guard #(.N(N), .DEFAULT_SEED(DEFAULT_SEED)) u_guard (
        .seed_in  (seed),
        .seed_out (seed_safe)
    );

    // Decode the mode select into the advance type.
    assign mode = adv_mode_e'(jump);

    // Choose the next state: load first, then the selected advance, else hold.
    always_comb begin
        if (load) begin
            state_d = seed_safe;
        end else if (en) begin
            unique case (mode)
                ADV_JUMP:   state_d = jump_nxt;
                default:    state_d = single_nxt;
            endcase
        end else begin
            state_d = state_q;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DEFAULT_SEED;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/sslfsr_gen_chk.sv
// Checker for sslfsr_gen, attached by bind. Works on ports only, and works out
// the jump target by iterating single steps, not with the matrix.
module sslfsr_gen_chk #(
    parameter int            N            = 16,
    parameter logic [N-1:0]  TAP_MASK     = 16'hB400,
    parameter int            SKIP         = 8,
    parameter logic [N-1:0]  DEFAULT_SEED = 16'hACE1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic         load,
    input logic [N-1:0] seed,
    input logic         jump,
    input logic [N-1:0] state
);

    // One single step, written as an explicit loop.
    function automatic logic [N-1:0] one_step(logic [N-1:0] v);
        logic p;
        p = 1'b0;
        for (int b = 0; b < N; b++) p = p ^ (v[b] & TAP_MASK[b]);
        return {v[N-2:0], p};
    endfunction

    // SKIP single steps in a row.
    function automatic logic [N-1:0] many_steps(logic [N-1:0] v);
        logic [N-1:0] t;
        t = v;
        for (int s = 0; s < SKIP; s++) t = one_step(t);
        return t;
    endfunction

    // R1
    reset_value_chk: assert property (@(posedge clk) !rst_n |=> (state == DEFAULT_SEED));

    // R2
    load_takes_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != '0) |=> (state == $past(seed)));

    // R3
    zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> (state == DEFAULT_SEED));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(state));

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && !jump) |=> (state == one_step($past(state))));

    // R6
    jump_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && jump) |=> (state == many_steps($past(state))));

    // R8
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (state != '0));

endmodule

bind sslfsr_gen sslfsr_gen_chk #(
    .N(N), .TAP_MASK(TAP_MASK), .SKIP(SKIP), .DEFAULT_SEED(DEFAULT_SEED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load),
    .seed(seed), .jump(jump), .state(state)
);

// File: tb/sslfsr_gen_bench.sv
`timescale 1ns/1ps
// Bench for sslfsr_gen: a behavioural reference model is compared after every clock.
module sslfsr_gen_bench;

    localparam logic [15:0] TAP = 16'hB400;
    localparam logic [15:0] DEF = 16'hACE1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [15:0] seed = '0;
    logic        jump = 1'b0;
    logic [15:0] state;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] expv = DEF;
    logic [15:0] snap_a;
    logic [15:0] snap_b;
    int          period;

    sslfsr_gen u_sslfsr_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .seed(seed), .jump(jump), .state(state)
    );

    always #4 clk = ~clk;

    // Model: one step, by counting tapped ones.
    function automatic logic [15:0] mstep(logic [15:0] v);
        int ones;
        ones = 0;
        for (int b = 0; b < 16; b++) if (TAP[b] && v[b]) ones++;
        return {v[14:0], ones[0]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Apply inputs for one edge, update the model, compare after the edge.
    task automatic cyc(input logic l, input logic [15:0] s, input logic e,
                       input logic j, input string req);
        load = l; seed = s; en = e; jump = j;
        @(posedge clk);
        #1;
        if (l)      expv = (s == 16'h0) ? DEF : s;
        else if (e) begin
            if (j) for (int k = 0; k < 8; k++) expv = mstep(expv);
            else   expv = mstep(expv);
        end
        check(req, state, expv);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", state, DEF);
        rst_n = 1'b1;
        cyc(1'b0, 16'h0, 1'b0, 1'b0, "R1 after release");

        // R5 single steps from the default
        for (int i = 0; i < 20; i++) cyc(1'b0, 16'h0, 1'b1, 1'b0, "R5 single");

        // R2 load while en low and jump high
        cyc(1'b1, 16'h1234, 1'b0, 1'b1, "R2 load en low");
        cyc(1'b1, 16'hBEEF, 1'b1, 1'b1, "R2 load over jump");
        // R3 zero seed, then a nonzero one
        cyc(1'b1, 16'h0000, 1'b1, 1'b0, "R3 zero seed");
        cyc(1'b1, 16'h0001, 1'b0, 1'b0, "R3 nonzero seed");

        // R4 hold with either mode
        cyc(1'b0, 16'h0, 1'b0, 1'b1, "R4 hold jump");
        cyc(1'b0, 16'h0, 1'b0, 1'b0, "R4 hold single");
        check("R4 held value", state, 16'h0001);

        // R6 one jump equals eight single steps, several seeds
        foreach (snap_a[i]) begin end
        for (int n = 0; n < 5; n++) begin
            logic [15:0] sd;
            sd = 16'h1D0F ^ (16'h9E37 * (n + 1)) ^ 16'(n);
            cyc(1'b1, sd, 1'b0, 1'b0, "R6 seed");
            cyc(1'b0, 16'h0, 1'b1, 1'b1, "R6 jump");
            snap_a = state;
            cyc(1'b1, sd, 1'b0, 1'b0, "R6 reseed");
            for (int k = 0; k < 8; k++) cyc(1'b0, 16'h0, 1'b1, 1'b0, "R6 singles");
            snap_b = state;
            check("R6 jump vs eight singles", snap_a, snap_b);
        end

        // R7 mixed single steps and jumps, with gaps
        for (int i = 0; i < 40; i++)
            cyc(1'b0, 16'h0, (i % 5) != 3, (i % 3) == 0, "R7 mixed");

        // R8 period of the single-step sequence
        cyc(1'b1, 16'h0001, 1'b0, 1'b0, "R8 start");
        period = 0;
        do begin
            cyc(1'b0, 16'h0, 1'b1, 1'b0, "R8 run");
            period++;
            if (state == 16'h0) check("R8 nonzero", state, 16'h0001);
        end while (state != 16'h0001 && period < 70000);
        check("R8 period", 16'(period), 16'(65535));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule